// File: doc/BRIEF.md
# Translation Table Update Engine

This block keeps a small table of 64-bit translation entries for one DMA window. It runs one command at a time against that table. A command can store a single entry, return a single entry, put one value into a run of consecutive pages, or copy a run of values fetched from a list in memory into consecutive pages. Each command carries a 64-bit table identifier, a bus address, a value (an entry, or a list address for the list command) and a page count. When it completes, the block pulses `done` for one cycle and reports a status of 0 (success) or 1 (parameter error). A successful read also returns the entry on `result`.

Every entry the block writes raises a one-cycle notification. The notification carries the page-aligned window offset, the page-aligned target address taken from the entry, the in-page mask and a 2-bit permission code. A downstream translation cache can drop or refresh its copy of that page from this notice. List entries arrive through a simple read port. Only one read is outstanding at a time, and every word read is taken as big-endian.

Top module: `tte_engine`

## Requirements
- R1: A command is rejected with status 1 if the identifier has any nonzero bit in bits 63:32, or if bits 31:0 differ from the configured identifier. A rejected command writes no entry and raises no notification.
- R2: Before use, the bus address is ANDed with the page mask. The slot is (masked address − window base) >> page shift. A slot at or beyond the entry count gives status 1 and leaves the table unchanged.
- R3: Command code 0 stores the value in the addressed slot. Command code 1 returns that slot's stored value unmodified on `result`. Both codes ignore the page count.
- R4: Command code 3 is rejected if the page count is above 512 or if bits 11:0 of the list address are nonzero. Otherwise it reads word i from list address + 8·i, one request at a time. It takes byte k of `mem_rdata` (bits 8k+7:8k) as the byte at address + 8·i + k, with byte 0 the most significant, and writes the result to page i of the run.
- R5: Command code 2 is rejected if the page count exceeds the entry count. Otherwise it writes the same value into consecutive pages, starting at the masked address and stepping by one page size.
- R6: A multi-page command stops at the first page whose slot is out of range. Its status is that of the last page attempted, and pages written before that one keep their new values.
- R7: Each entry write raises `note_valid` for one cycle, one cycle after the write. The notice carries: the offset (address − base) ANDed with the page mask; the entry ANDed with the page mask; the inverted page mask; and entry bits 1:0 as the permission (0 none, 1 read, 2 write, 3 read-write).
- R8: `result` changes only on a successful read. A failed read leaves it unchanged.
- R9: `cmd_ready` is high only when the engine is idle. `done` is a one-cycle pulse raised while the engine is idle. A page count of zero for code 2 or code 3 completes with status 1 and no write.
- R10: Reset clears every table entry to zero, clears `result`, and deasserts `done`, `note_valid` and `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_op | input | 2 | 0 store, 1 read, 2 fill, 3 list |
| cmd_id | input | 64 | Table identifier |
| cmd_addr | input | 64 | Bus address of the first page |
| cmd_val | input | 64 | Entry value, or list address for code 3 |
| cmd_count | input | CNT_W | Page count |
| done | output | 1 | Completion pulse |
| status | output | 1 | 0 success, 1 parameter error, valid with done |
| result | output | 64 | Entry returned by the last successful read |
| mem_req | output | 1 | List word read request, one cycle |
| mem_addr | output | 64 | List word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, byte k = address + k |
| note_valid | output | 1 | Entry write notification |
| note_iova | output | 64 | Page-aligned window offset |
| note_xlat | output | 64 | Page-aligned target from the entry |
| note_mask | output | 64 | In-page mask |
| note_perm | output | 2 | Permission code from entry bits 1:0 |

## Verification
The checks assume two things about the inputs. First, the memory port answers each request with exactly one `mem_rvalid` and raises none unasked. Second, commands are offered only while `cmd_ready` is high, which means a request never overlaps the previous one. The bench keeps to this: its memory model answers one cycle after it sees a request, and it offers a command only after the previous `done`. The window base and list addresses used are page-aligned, as the notice checks expect.

// File: rtl/tte_pkg.sv
package tte_pkg;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_GET  = 2'd1,
    OP_FILL = 2'd2,
    OP_LIST = 2'd3
  } tte_op_e;

  localparam logic ST_OK    = 1'b0;
  localparam logic ST_PARAM = 1'b1;

  // Mask that clears the in-page bits for a page of 2**sh bytes.
  function automatic logic [63:0] pg_mask(input int unsigned sh);
    return ~((64'd1 << sh) - 64'd1);
  endfunction

  // Slot number of a masked bus address within the window.
  function automatic logic [63:0] slot_of(input logic [63:0] addr,
                                          input logic [63:0] base,
                                          input int unsigned sh);
    return (addr - base) >> sh;
  endfunction

  // Memory bytes arrive in address order; the first byte is most significant.
  function automatic logic [63:0] be64_swap(input logic [63:0] w);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = w[8*(7-k) +: 8];
    return r;
  endfunction

  function automatic logic [1:0] perm_of(input logic [63:0] e);
    return e[1:0];
  endfunction

endpackage

// File: rtl/tte_precheck.sv
module tte_precheck import tte_pkg::*; #(
  parameter logic [31:0] TABLE_ID   = 32'h8000_0001,
  parameter int          ENTRIES    = 16,
  parameter int          MAX_LIST   = 512,
  parameter int          LIST_ALIGN = 12,
  parameter int          CNT_W      = 32
) (
  input  tte_op_e               op,
  input  logic [63:0]           id,
  input  logic [LIST_ALIGN-1:0] list_lo,
  input  logic [CNT_W-1:0]      count,
  output logic                  reject
);
  logic id_bad;
  logic count_bad;

  always_comb begin
    id_bad = (id[63:32] != 32'd0) || (id[31:0] != TABLE_ID);
    case (op)
      OP_FILL: count_bad = (count == '0) || (count > CNT_W'(ENTRIES));
      OP_LIST: count_bad = (count == '0) || (count > CNT_W'(MAX_LIST)) ||
                           (list_lo != '0);
      default: count_bad = 1'b0;
    endcase
    reject = id_bad || count_bad;
  end
endmodule

// File: rtl/tte_table.sv
module tte_table #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [63:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [63:0]      rdata
);
  logic [63:0] slots [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
    end else if (we) begin
      slots[widx] <= wdata;
    end
  end

  assign rdata = slots[ridx];
endmodule

// File: rtl/tte_notify.sv
module tte_notify import tte_pkg::*; #(
  parameter int PAGE_SHIFT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic [63:0] off_addr,
  input  logic [63:0] entry,
  output logic        note_valid,
  output logic [63:0] note_iova,
  output logic [63:0] note_xlat,
  output logic [63:0] note_mask,
  output logic [1:0]  note_perm
);
  localparam logic [63:0] PMASK = pg_mask(PAGE_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      note_valid <= 1'b0;
      note_iova  <= '0;
      note_xlat  <= '0;
      note_mask  <= '0;
      note_perm  <= '0;
    end else begin
      note_valid <= fire;
      if (fire) begin
        note_iova <= off_addr & PMASK;
        note_xlat <= entry & PMASK;
        note_mask <= ~PMASK;
        note_perm <= perm_of(entry);
      end
    end
  end
endmodule

// File: rtl/tte_engine.sv
module tte_engine import tte_pkg::*; #(
  parameter logic [31:0] TABLE_ID   = 32'h8000_0001,
  parameter int          ENTRIES    = 16,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [63:0] WIN_BASE   = 64'h0000_0000_0001_0000,
  parameter int          MAX_LIST   = 512,
  parameter int          CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [63:0]      cmd_id,
  input  logic [63:0]      cmd_addr,
  input  logic [63:0]      cmd_val,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             done,
  output logic             status,
  output logic [63:0]      result,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata,
  output logic             note_valid,
  output logic [63:0]      note_iova,
  output logic [63:0]      note_xlat,
  output logic [63:0]      note_mask,
  output logic [1:0]       note_perm
);
  localparam int          IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int          LIST_ALIGN = 12;
  localparam logic [63:0] PMASK      = pg_mask(PAGE_SHIFT);
  localparam logic [63:0] PSIZE      = 64'd1 << PAGE_SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_EXEC} seq_e;

  seq_e             state;
  tte_op_e          op_q;
  logic [63:0]      addr_q;
  logic [63:0]      val_q;
  logic [63:0]      list_q;
  logic [CNT_W-1:0] left_q;

  // Named internal events
  tte_op_e     op_in;
  logic        accept;
  logic        reject;
  logic [63:0] slot;
  logic        slot_ok;
  logic        last_one;
  logic        wr_fire;
  logic [63:0] tbl_rdata;

  assign op_in     = tte_op_e'(cmd_op);
  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign slot      = slot_of(addr_q, WIN_BASE, PAGE_SHIFT);
  assign slot_ok   = (slot < 64'(ENTRIES));
  assign last_one  = (left_q == CNT_W'(1));
  assign wr_fire   = (state == S_EXEC) && slot_ok && (op_q != OP_GET);
  assign mem_req   = (state == S_FETCH);
  assign mem_addr  = list_q;

  tte_precheck #(
    .TABLE_ID(TABLE_ID), .ENTRIES(ENTRIES), .MAX_LIST(MAX_LIST),
    .LIST_ALIGN(LIST_ALIGN), .CNT_W(CNT_W)
  ) u_pre (
    .op(op_in), .id(cmd_id), .list_lo(cmd_val[LIST_ALIGN-1:0]),
    .count(cmd_count), .reject(reject)
  );

  tte_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(wr_fire),
    .widx(slot[IDX_W-1:0]), .wdata(val_q),
    .ridx(slot[IDX_W-1:0]), .rdata(tbl_rdata)
  );

  tte_notify #(.PAGE_SHIFT(PAGE_SHIFT)) u_note (
    .clk(clk), .rst_n(rst_n), .fire(wr_fire),
    .off_addr(addr_q - WIN_BASE), .entry(val_q),
    .note_valid(note_valid), .note_iova(note_iova), .note_xlat(note_xlat),
    .note_mask(note_mask), .note_perm(note_perm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_PUT;
      addr_q <= '0;
      val_q  <= '0;
      list_q <= '0;
      left_q <= '0;
      done   <= 1'b0;
      status <= ST_OK;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            op_q   <= op_in;
            addr_q <= cmd_addr & PMASK;
            val_q  <= cmd_val;
            list_q <= cmd_val;
            left_q <= (op_in == OP_FILL || op_in == OP_LIST) ? cmd_count
                                                             : CNT_W'(1);
            if (reject) begin
              done   <= 1'b1;
              status <= ST_PARAM;
            end else begin
              state <= (op_in == OP_LIST) ? S_FETCH : S_EXEC;
            end
          end
        end
        S_FETCH: state <= S_WAIT;
        S_WAIT: begin
          if (mem_rvalid) begin
            val_q <= be64_swap(mem_rdata);
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (!slot_ok) begin
            done   <= 1'b1;
            status <= ST_PARAM;
            state  <= S_IDLE;
          end else if (op_q == OP_GET) begin
            result <= tbl_rdata;
            done   <= 1'b1;
            status <= ST_OK;
            state  <= S_IDLE;
          end else if (last_one) begin
            done   <= 1'b1;
            status <= ST_OK;
            state  <= S_IDLE;
          end else begin
            left_q <= left_q - CNT_W'(1);
            addr_q <= addr_q + PSIZE;
            list_q <= list_q + 64'd8;
            state  <= (op_q == OP_LIST) ? S_FETCH : S_EXEC;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tte_engine_chk.sv
module tte_engine_chk #(
  parameter int ENTRIES    = 16,
  parameter int PAGE_SHIFT = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        done,
  input logic        status,
  input logic [63:0] result,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic        note_valid,
  input logic [63:0] note_iova,
  input logic [63:0] note_xlat,
  input logic [63:0] note_mask
);
  localparam logic [63:0] INPAGE = (64'd1 << PAGE_SHIFT) - 64'd1;

  assert_fetch_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'd0) && !cmd_ready);

  assert_fetch_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_note_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> (note_mask == INPAGE) && ((note_iova & INPAGE) == 64'd0) &&
                   ((note_xlat & INPAGE) == 64'd0));

  assert_note_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> ((note_iova >> PAGE_SHIFT) < 64'(ENTRIES)));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done || status) |-> $stable(result));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
endmodule

bind tte_engine tte_engine_chk #(.ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done), .status(status),
  .result(result), .mem_req(mem_req), .mem_addr(mem_addr), .note_valid(note_valid),
  .note_iova(note_iova), .note_xlat(note_xlat), .note_mask(note_mask)
);

// File: tb/sim_tte_engine.sv
`timescale 1ns/1ps
module sim_tte_engine;
  localparam int          ENT   = 16;
  localparam logic [63:0] PSZ   = 64'd4096;
  localparam logic [63:0] BASE  = 64'h1_0000;
  localparam logic [63:0] TID   = 64'h8000_0001;
  localparam logic [63:0] LBASE = 64'h2_0000;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [63:0] cmd_id = 0, cmd_addr = 0, cmd_val = 0;
  logic [31:0] cmd_count = 0;
  logic mem_rvalid = 0;
  logic [63:0] mem_rdata = 0;
  logic cmd_ready, done, status, mem_req, note_valid;
  logic [63:0] result, mem_addr, note_iova, note_xlat, note_mask;
  logic [1:0] note_perm;

  tte_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_addr(cmd_addr), .cmd_val(cmd_val),
    .cmd_count(cmd_count), .done(done), .status(status), .result(result),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .note_valid(note_valid), .note_iova(note_iova),
    .note_xlat(note_xlat), .note_mask(note_mask), .note_perm(note_perm)
  );

  initial forever #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [63:0] mtbl [ENT];
  logic [63:0] lmem [64];
  logic [63:0] exp_res = 0;
  logic        exp_st;
  int          en_n;
  logic [63:0] en_iova [600];
  logic [63:0] en_xlat [600];
  logic [1:0]  en_perm [600];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] swap8(input logic [63:0] v);
    logic [63:0] r = 0;
    for (int k = 0; k < 8; k++) r = (r << 8) | ((v >> (8*k)) & 64'hFF);
    return r;
  endfunction

  // Attempt one page; returns 1 if it was in the window.
  function automatic bit model_page(input logic [63:0] a, input logic [63:0] v);
    if (a < BASE || a - BASE >= PSZ * ENT) return 0;
    mtbl[(a - BASE) / PSZ] = v;
    en_iova[en_n] = a - BASE;
    en_xlat[en_n] = v - (v % PSZ);
    en_perm[en_n] = 2'(v % 4);
    en_n++;
    return 1;
  endfunction

  task automatic model(input logic [1:0] op, input logic [63:0] id, input logic [63:0] addr,
                       input logic [63:0] val, input logic [31:0] cnt);
    logic [63:0] a;
    bit ok;
    en_n = 0;
    a = addr - (addr % PSZ);
    exp_st = 1;
    if (id != TID) return;
    case (op)
      2'd0: exp_st = !model_page(a, val);
      2'd1: if (a >= BASE && a - BASE < PSZ * ENT) begin
              exp_res = mtbl[(a - BASE) / PSZ];
              exp_st = 0;
            end
      2'd2: if (cnt != 0 && cnt <= ENT) begin
              for (int i = 0; i < cnt; i++) begin
                ok = model_page(a + PSZ * i, val);
                exp_st = !ok;
                if (!ok) break;
              end
            end
      default: if (cnt != 0 && cnt <= 512 && val % 4096 == 0) begin
              for (int i = 0; i < cnt; i++) begin
                ok = model_page(a + PSZ * i, lmem[((val - LBASE) / 8 + i) % 64]);
                exp_st = !ok;
                if (!ok) break;
              end
            end
    endcase
  endtask

  task automatic run(input logic [1:0] op, input logic [63:0] id, input logic [63:0] addr,
                     input logic [63:0] val, input logic [31:0] cnt, input string tag);
    int gn = 0;
    int waited = 0;
    logic [63:0] g_iova [600];
    logic [63:0] g_xlat [600];
    logic [1:0]  g_perm [600];
    model(op, id, addr, val, cnt);
    @(negedge clk);
    cmd_op = op; cmd_id = id; cmd_addr = addr; cmd_val = val; cmd_count = cnt;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    while (1) begin
      if (note_valid && gn < 600) begin
        g_iova[gn] = note_iova; g_xlat[gn] = note_xlat; g_perm[gn] = note_perm; gn++;
        chk(note_mask == PSZ - 1, {tag, " note mask R7"}, note_mask, PSZ - 1);
      end
      if (done) break;
      waited++;
      if (waited > 5000) begin
        chk(0, {tag, " no done"}, 0, 1);
        return;
      end
      @(negedge clk);
    end
    chk(status == exp_st, {tag, " status"}, 64'(status), 64'(exp_st));
    chk(result == exp_res, {tag, " result R8"}, result, exp_res);
    chk(gn == en_n, {tag, " note count R7"}, 64'(gn), 64'(en_n));
    for (int i = 0; i < gn && i < en_n; i++) begin
      chk(g_iova[i] == en_iova[i], {tag, " note offset R7"}, g_iova[i], en_iova[i]);
      chk(g_xlat[i] == en_xlat[i], {tag, " note target R7"}, g_xlat[i], en_xlat[i]);
      chk(g_perm[i] == en_perm[i], {tag, " note perm R7"}, 64'(g_perm[i]), 64'(en_perm[i]));
    end
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < ENT; i++) run(2'd1, TID, BASE + PSZ * i + 64'(i * 8), 0, 0, tag);
  endtask

  // Memory responder: answer one cycle after a request.
  initial begin
    logic [63:0] ra;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (mem_req) begin
        ra = mem_addr;
        @(negedge clk);
        mem_rdata = swap8(lmem[((ra - LBASE) / 8) % 64]);
        mem_rvalid = 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) mtbl[i] = 0;
    for (int i = 0; i < 64; i++) lmem[i] = 64'h0123_4567_0000_0000 + 64'(i * 64'h1_0003);
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1, "reset ready R10", 64'(cmd_ready), 1);
    chk(done == 0 && note_valid == 0 && mem_req == 0, "reset pulses R10",
        {61'd0, done, note_valid, mem_req}, 0);
    chk(result == 0, "reset result R10", result, 0);
    rst_n = 1;
    sweep("R10 cleared table");

    for (int i = 0; i < ENT; i++)
      run(2'd0, TID, BASE + PSZ * i + 64'((i * 37) % 4096),
          64'hA5A5_0000_0000_0000 ^ (64'(i) << 20) ^ 64'(i * 12'h111), 0, "R3 R2 store");
    sweep("R3 readback");
    run(2'd0, TID, BASE + PSZ * 3, 64'hDEAD_BEEF_0000_1003, 7, "R3 count ignored");
    run(2'd1, TID, BASE + PSZ * 3, 0, 9, "R3 read count ignored");

    run(2'd0, TID, BASE + PSZ * ENT, 64'h1, 0, "R2 above window");
    run(2'd0, TID, BASE - 1, 64'h2, 0, "R2 below window");
    run(2'd1, TID, BASE + PSZ * ENT + 5, 0, 0, "R8 failed read");
    run(2'd1, TID, BASE - PSZ, 0, 0, "R8 failed read low");

    run(2'd0, TID | (64'd1 << 32), BASE, 64'h55, 0, "R1 upper id bit");
    run(2'd0, 64'h8000_0002, BASE, 64'h55, 0, "R1 wrong id");
    run(2'd1, TID | (64'd1 << 63), BASE, 0, 0, "R1 read bad id");
    run(2'd2, 64'h0, BASE, 64'h77, 2, "R1 fill bad id");
    run(2'd3, TID ^ 64'h1, BASE, LBASE, 2, "R1 list bad id");
    sweep("R1 table untouched");

    run(2'd2, TID, BASE, 64'h99, 0, "R9 fill zero count");
    run(2'd2, TID, BASE, 64'h99, ENT + 1, "R5 fill too long");
    run(2'd2, TID, BASE + 17, 64'h0000_0000_00AB_C002, ENT, "R5 fill whole");
    run(2'd2, TID, BASE + PSZ * 2, 64'h1111_2222_3333_4001, 4, "R5 fill run");
    run(2'd2, TID, BASE + PSZ * 14, 64'h7777_0000_0000_0003, 4, "R6 fill off end");
    sweep("R6 fill kept");

    run(2'd3, TID, BASE, LBASE, 513, "R4 list too long");
    run(2'd3, TID, BASE, LBASE + 8, 2, "R4 list misaligned");
    run(2'd3, TID, BASE, LBASE + 64'h800, 2, "R4 list misaligned half");
    run(2'd3, TID, BASE, LBASE, 0, "R9 list zero count");
    run(2'd3, TID, BASE + PSZ * 3, LBASE, 5, "R4 list run");
    sweep("R4 list readback");
    run(2'd3, TID, BASE, LBASE + 4096, 512, "R6 list max count off end");
    run(2'd3, TID, BASE + PSZ * 13, LBASE, 6, "R6 list off end");
    sweep("R6 list kept");

    for (int op = 0; op < 4; op++)
      for (int p = -1; p <= ENT; p += 4)
        run(2'(op), TID, BASE + PSZ * p, LBASE, 3, "R2 sweep");
    sweep("R2 sweep readback");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule